// File: doc/BRIEF.md
# Configuration Port Register Bridge

This block is a register-mapped slave that sits between a simple register read/write bus and a 32-bit configuration port. Software loads configuration words into a write queue and then sets a control bit. The bridge then hands the queued words, oldest first, to the port over a valid/ready handshake. For readback, software loads a word count into a size register and sets a second control bit. The bridge then accepts exactly that many words from the port into a read queue, and software collects them one register read at a time.

Both transfer bits clear themselves when their transfer ends. A done flag, queue vacancy and occupancy counts, and a maskable completion interrupt let software follow progress by polling or by interrupt. Register reads are combinational from the current state. A read of the read-queue register removes the word it returns at the clock edge that ends the access.

Register offsets (byte addresses): global interrupt enable 0x1C, interrupt status 0x20, interrupt enable 0x28, write queue 0x100, read queue 0x104, size 0x108, control 0x10C, status 0x110, write-queue vacancy 0x114, read-queue occupancy 0x118.

Top module: `cfgBridge`

## Requirements
- R1: After reset the control register reads 0, status bit 0 reads 1, vacancy reads the write-queue depth (16), occupancy reads 0 and irq is low.
- R2: A write to 0x100 stores the word when the write queue is not full, and vacancy at 0x114 falls by one for each stored word. A write to 0x100 when the queue is full is dropped, and the dropped word never reaches the port.
- R3: Writing control bit 0 starts a drain. Queued words appear on portOutData in the order they were written, one per valid/ready handshake. Control bit 0 reads 1 during the drain and clears by itself once the write queue is empty.
- R4: Writing control bit 1 starts a readback. Exactly the count held in the size register (0x108) is accepted from the port, and then control bit 1 clears by itself. Occupancy at 0x118 then equals that count. A count of 0 completes at once.
- R5: Control bits 0 and 1 are never set together. A control write with both bits set starts only the drain. Any control write while a transfer is active is ignored.
- R6: Status bit 0 (0x110) reads 0 while a drain or readback is active and 1 otherwise.
- R7: A read of 0x104 returns the oldest word in the read queue and removes it. When the read queue is empty the read returns 0.
- R8: Interrupt status bit 0 (0x20) is set when a drain or readback completes. Writing 1 to that bit clears it.
- R9: irq equals interrupt status bit 0 AND interrupt enable bit 0 (0x28) AND global enable bit 31 (0x1C).
- R10: While portOutValid is high and portOutReady is low, portOutValid stays high and portOutData holds its value on the next cycle.
- R11: During readback, portInReady is low while the read queue is full. The transfer stays active and resumes once software removes words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; a read of 0x104 pops at the clock edge |
| regAddr | input | ADDR_W (12) | Byte address of the register |
| regWdata | input | WORD_W (32) | Register write data |
| regRdata | output | WORD_W (32) | Register read data, combinational |
| portOutValid | output | 1 | Drain word available on the port |
| portOutReady | input | 1 | Port accepts the drain word |
| portOutData | output | WORD_W (32) | Drain word |
| portInValid | input | 1 | Port offers a readback word |
| portInReady | output | 1 | Bridge accepts the readback word |
| portInData | input | WORD_W (32) | Readback word |
| irq | output | 1 | Masked completion interrupt |

## Verification
The assertions check four things on every cycle. The two transfer bits are never both set. A drain ends only with an empty write queue. The interrupt status rises only from an active transfer. A stalled drain word holds steady. The queues are also checked for overflow and underflow. Only the bench scenarios can show the end-to-end results. These include word order through both queues and dropping of writes to a full queue. They also include the exact readback count, the stall and resume around a full read queue, the ignored control writes and the three-way interrupt mask.

// File: rtl/cfgBridgePkg.sv
package cfgBridgePkg;
  // register byte offsets; software depends on these
  localparam logic [11:0] OffGie  = 12'h01C;
  localparam logic [11:0] OffIsr  = 12'h020;
  localparam logic [11:0] OffIer  = 12'h028;
  localparam logic [11:0] OffWq   = 12'h100;
  localparam logic [11:0] OffRq   = 12'h104;
  localparam logic [11:0] OffSize = 12'h108;
  localparam logic [11:0] OffCtl  = 12'h10C;
  localparam logic [11:0] OffStat = 12'h110;
  localparam logic [11:0] OffVac  = 12'h114;
  localparam logic [11:0] OffOcc  = 12'h118;

  // strobes from control to datapath
  typedef struct packed {
    logic wqPush;
    logic wqPop;
    logic rqPush;
    logic rqPop;
  } queueStrobes_t;
endpackage

// File: rtl/cfgBridgeFifo.sv
module cfgBridgeFifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16   // power of two
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       push,
  input  logic                       pop,
  input  logic [WIDTH-1:0]           wdata,
  output logic [WIDTH-1:0]           head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign head = mem[rdPtr];

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (count < CW'(DEPTH) || pop));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> count != '0);
endmodule

// File: rtl/cfgBridgeData.sv
module cfgBridgeData
  import cfgBridgePkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int WQ_DEPTH = 16,
  parameter int RQ_DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  queueStrobes_t                 strb,
  input  logic [WORD_W-1:0]             regWdata,
  input  logic [WORD_W-1:0]             portInData,
  output logic [WORD_W-1:0]             wqHead,
  output logic [WORD_W-1:0]             rqHead,
  output logic [$clog2(WQ_DEPTH+1)-1:0] wqCount,
  output logic [$clog2(RQ_DEPTH+1)-1:0] rqCount
);
  cfgBridgeFifo #(.WIDTH(WORD_W), .DEPTH(WQ_DEPTH)) wrQueue (
    .clk(clk), .rstN(rstN), .push(strb.wqPush), .pop(strb.wqPop),
    .wdata(regWdata), .head(wqHead), .count(wqCount));

  cfgBridgeFifo #(.WIDTH(WORD_W), .DEPTH(RQ_DEPTH)) rdQueue (
    .clk(clk), .rstN(rstN), .push(strb.rqPush), .pop(strb.rqPop),
    .wdata(portInData), .head(rqHead), .count(rqCount));
endmodule

// File: rtl/cfgBridgeCtrl.sv
module cfgBridgeCtrl
  import cfgBridgePkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int WORD_W   = 32,
  parameter int WQ_DEPTH = 16,
  parameter int RQ_DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWrEn,
  input  logic                          regRdEn,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [WORD_W-1:0]             regWdata,
  output logic [WORD_W-1:0]             regRdata,
  input  logic                          portOutReady,
  output logic                          portOutValid,
  input  logic                          portInValid,
  output logic                          portInReady,
  output logic                          irq,
  output queueStrobes_t                 strb,
  input  logic [WORD_W-1:0]             wqHead,
  input  logic [WORD_W-1:0]             rqHead,
  input  logic [$clog2(WQ_DEPTH+1)-1:0] wqCount,
  input  logic [$clog2(RQ_DEPTH+1)-1:0] rqCount
);
  localparam int WCW = $clog2(WQ_DEPTH+1);
  localparam int RCW = $clog2(RQ_DEPTH+1);

  logic wrBit, rdBit, isrBit;
  logic [WORD_W-1:0] gieReg, ierReg, sizeReg, remaining;

  logic wqFull, rqFull, idle, ctlWrite, startWr, startRd, wrFinish, rdFinish;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] off);
    return a == ADDR_W'(off);
  endfunction

  assign wqFull   = wqCount == WCW'(WQ_DEPTH);
  assign rqFull   = rqCount == RCW'(RQ_DEPTH);
  assign idle     = !wrBit && !rdBit;
  assign ctlWrite = regWrEn && hit(regAddr, OffCtl);
  assign startWr  = ctlWrite && idle && regWdata[0];
  assign startRd  = ctlWrite && idle && !regWdata[0] && regWdata[1];
  assign wrFinish = wrBit && wqCount == '0;
  assign rdFinish = rdBit && remaining == '0;

  assign portOutValid = wrBit && wqCount != '0;
  assign portInReady  = rdBit && remaining != '0 && !rqFull;

  assign strb.wqPush = regWrEn && hit(regAddr, OffWq) && !wqFull;
  assign strb.wqPop  = portOutValid && portOutReady;
  assign strb.rqPush = portInReady && portInValid;
  assign strb.rqPop  = regRdEn && hit(regAddr, OffRq) && rqCount != '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrBit     <= 1'b0;
      rdBit     <= 1'b0;
      isrBit    <= 1'b0;
      gieReg    <= '0;
      ierReg    <= '0;
      sizeReg   <= '0;
      remaining <= '0;
    end else begin
      if (startWr)       wrBit <= 1'b1;
      else if (wrFinish) wrBit <= 1'b0;
      if (startRd)       rdBit <= 1'b1;
      else if (rdFinish) rdBit <= 1'b0;
      if (startRd)          remaining <= sizeReg;
      else if (strb.rqPush) remaining <= remaining - 1'b1;
      if (wrFinish || rdFinish)                                 isrBit <= 1'b1;
      else if (regWrEn && hit(regAddr, OffIsr) && regWdata[0]) isrBit <= 1'b0;
      if (regWrEn && hit(regAddr, OffGie))  gieReg  <= regWdata;
      if (regWrEn && hit(regAddr, OffIer))  ierReg  <= regWdata;
      if (regWrEn && hit(regAddr, OffSize)) sizeReg <= regWdata;
    end
  end

  assign irq = isrBit && ierReg[0] && gieReg[WORD_W-1];

  always_comb begin
    regRdata = '0;
    if (regRdEn) begin
      if (hit(regAddr, OffGie))  regRdata = {gieReg[WORD_W-1], {(WORD_W-1){1'b0}}};
      if (hit(regAddr, OffIsr))  regRdata = WORD_W'(isrBit);
      if (hit(regAddr, OffIer))  regRdata = ierReg;
      if (hit(regAddr, OffRq) && rqCount != '0) regRdata = rqHead;
      if (hit(regAddr, OffSize)) regRdata = sizeReg;
      if (hit(regAddr, OffCtl))  regRdata = WORD_W'({rdBit, wrBit});
      if (hit(regAddr, OffStat)) regRdata = WORD_W'(idle);
      if (hit(regAddr, OffVac))  regRdata = WORD_W'(WQ_DEPTH) - WORD_W'(wqCount);
      if (hit(regAddr, OffOcc))  regRdata = WORD_W'(rqCount);
    end
  end

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(wrBit && rdBit));
  assert_drain_empty_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrBit) |-> wqCount == '0);
  assert_read_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdBit) |-> remaining == '0);
  assert_isr_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isrBit) |-> $past(wrBit || rdBit));
  assert_hold_word_R10: assert property (@(posedge clk) disable iff (!rstN)
    (portOutValid && !portOutReady) |=> (portOutValid && $stable(wqHead)));
  assert_full_stall_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.rqPush |-> (rqCount < RCW'(RQ_DEPTH) || strb.rqPop));
endmodule

// File: rtl/cfgBridge.sv
module cfgBridge
  import cfgBridgePkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int WORD_W   = 32,
  parameter int WQ_DEPTH = 16,
  parameter int RQ_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  output logic              portOutValid,
  input  logic              portOutReady,
  output logic [WORD_W-1:0] portOutData,
  input  logic              portInValid,
  output logic              portInReady,
  input  logic [WORD_W-1:0] portInData,
  output logic              irq
);
  localparam int WCW = $clog2(WQ_DEPTH+1);
  localparam int RCW = $clog2(RQ_DEPTH+1);

  queueStrobes_t strb;
  logic [WORD_W-1:0] wqHead, rqHead;
  logic [WCW-1:0] wqCount;
  logic [RCW-1:0] rqCount;

  cfgBridgeCtrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WQ_DEPTH(WQ_DEPTH), .RQ_DEPTH(RQ_DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .portOutReady(portOutReady),
    .portOutValid(portOutValid), .portInValid(portInValid), .portInReady(portInReady),
    .irq(irq), .strb(strb), .wqHead(wqHead), .rqHead(rqHead),
    .wqCount(wqCount), .rqCount(rqCount));

  cfgBridgeData #(.WORD_W(WORD_W), .WQ_DEPTH(WQ_DEPTH), .RQ_DEPTH(RQ_DEPTH)) data (
    .clk(clk), .rstN(rstN), .strb(strb), .regWdata(regWdata), .portInData(portInData),
    .wqHead(wqHead), .rqHead(rqHead), .wqCount(wqCount), .rqCount(rqCount));

  assign portOutData = wqHead;
endmodule

// File: tb/tb_cfgBridge.sv
module tb_cfgBridge;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic portOutValid, portOutReady = 1'b0;
  logic [31:0] portOutData;
  logic portInValid = 1'b0, portInReady;
  logic [31:0] portInData = 32'h1000_0001;
  logic irq;

  cfgBridge dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .portOutValid(portOutValid),
    .portOutReady(portOutReady), .portOutData(portOutData), .portInValid(portInValid),
    .portInReady(portInReady), .portInData(portInData), .irq(irq));

  always #5 clk = ~clk;

  int vecs = 0, errs = 0;
  int wqModel = 0;
  int cyc = 0;
  logic inHs = 1'b0;
  logic [31:0] drainQ[$];
  logic [31:0] readQ[$];
  logic [7:0] readyPat = 8'b1011_0110;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // port stimulus, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    portOutReady = readyPat[cyc % 8];
    portInValid  = rstN && (cyc % 3) != 0;
    if (inHs) portInData = portInData + 32'h0101_0101;
  end

  // monitor: sample between edges
  always @(negedge clk) begin
    inHs = rstN && portInValid && portInReady;
    if (inHs) readQ.push_back(portInData);
    if (rstN && portOutValid && portOutReady) begin
      if (drainQ.size() == 0) check("R2 unexpected drain word", portOutData, 32'hxxxx_xxxx);
      else check("R3 drain order", portOutData, drainQ.pop_front());
    end
  end

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    d = regRdata;
    @(posedge clk); #1;
    regRdEn = 1'b0;
  endtask

  task automatic pushWord(input logic [31:0] d);
    wrReg(12'h100, d);
    if (wqModel < DEPTH) begin
      drainQ.push_back(d);
      wqModel++;
    end
  endtask

  task automatic waitIdle(input string req);
    logic [31:0] v;
    logic done = 1'b0;
    for (int i = 0; i < 300 && !done; i++) begin
      rdReg(12'h10C, v);
      if (v[1:0] == 2'b00) done = 1'b1;
    end
    check(req, {31'd0, done}, 32'd1);
  endtask

  task automatic popCheck(input string req);
    logic [31:0] v;
    logic [31:0] exp;
    rdReg(12'h104, v);
    exp = (readQ.size() > 0) ? readQ.pop_front() : 32'h0;
    check(req, v, exp);
  endtask

  initial begin
    #500us;
    errs++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rdReg(12'h10C, v); check("R1 control", v, 32'd0);
    rdReg(12'h110, v); check("R1 status", v, 32'd1);
    rdReg(12'h114, v); check("R1 vacancy", v, 32'd16);
    rdReg(12'h118, v); check("R1 occupancy", v, 32'd0);
    @(negedge clk); check("R1 irq", {31'd0, irq}, 32'd0);

    // drain of 12 words
    for (int i = 0; i < 12; i++) pushWord(32'hA000_0000 + i);
    rdReg(12'h114, v); check("R2 vacancy", v, 32'd4);
    wrReg(12'h028, 32'd1);
    wrReg(12'h01C, 32'h8000_0000);
    wrReg(12'h10C, 32'd3);
    rdReg(12'h10C, v); check("R5 both bits start drain only", v, 32'd1);
    rdReg(12'h110, v); check("R6 busy status", v, 32'd0);
    wrReg(12'h10C, 32'd2);
    rdReg(12'h10C, v); check("R5 control write while busy", v, 32'd1);
    waitIdle("R3 write bit self-clears");
    wqModel = 0;
    check("R3 all words drained", drainQ.size(), 32'd0);
    rdReg(12'h110, v); check("R6 done status", v, 32'd1);
    rdReg(12'h020, v); check("R8 isr set", v, 32'd1);
    @(negedge clk); check("R9 irq fully enabled", {31'd0, irq}, 32'd1);
    wrReg(12'h020, 32'd1);
    rdReg(12'h020, v); check("R8 isr cleared", v, 32'd0);
    @(negedge clk); check("R9 irq after clear", {31'd0, irq}, 32'd0);

    // overfill: 18 writes, 16 kept
    for (int i = 0; i < 18; i++) pushWord(32'hB000_0000 + i);
    rdReg(12'h114, v); check("R2 vacancy full", v, 32'd0);
    wrReg(12'h01C, 32'd0);
    wrReg(12'h10C, 32'd1);
    waitIdle("R3 second drain");
    wqModel = 0;
    check("R2 only stored words drained", drainQ.size(), 32'd0);
    rdReg(12'h020, v); check("R8 isr after drain", v, 32'd1);
    @(negedge clk); check("R9 global enable masks irq", {31'd0, irq}, 32'd0);
    wrReg(12'h020, 32'd1);
    wrReg(12'h01C, 32'h8000_0000);

    // readback of 6
    wrReg(12'h108, 32'd6);
    wrReg(12'h10C, 32'd2);
    rdReg(12'h10C, v); check("R5 read bit only", v, 32'd2);
    waitIdle("R4 read bit self-clears");
    rdReg(12'h118, v); check("R4 occupancy equals size", v, 32'd6);
    check("R4 handshake count", readQ.size(), 32'd6);
    for (int i = 0; i < 6; i++) popCheck("R7 read order");
    popCheck("R7 empty read returns zero");
    rdReg(12'h020, v); check("R8 isr after readback", v, 32'd1);
    @(negedge clk); check("R9 irq after readback", {31'd0, irq}, 32'd1);
    wrReg(12'h020, 32'd1);

    // readback of 20 stalls at 16
    wrReg(12'h108, 32'd20);
    wrReg(12'h10C, 32'd2);
    repeat (80) @(posedge clk);
    rdReg(12'h118, v); check("R11 read queue full", v, 32'd16);
    rdReg(12'h10C, v); check("R11 transfer still active", v, 32'd2);
    @(negedge clk); check("R11 ready low when full", {31'd0, portInReady}, 32'd0);
    for (int i = 0; i < 16; i++) popCheck("R11 stalled words");
    waitIdle("R11 resumes and completes");
    rdReg(12'h118, v); check("R4 remaining words", v, 32'd4);
    for (int i = 0; i < 4; i++) popCheck("R7 tail words");
    check("R4 total accepted", readQ.size(), 32'd0);
    wrReg(12'h020, 32'd1);

    // zero-length readback
    wrReg(12'h108, 32'd0);
    wrReg(12'h10C, 32'd2);
    waitIdle("R4 zero count completes");
    rdReg(12'h118, v); check("R4 zero count occupancy", v, 32'd0);
    rdReg(12'h020, v); check("R8 isr on zero count", v, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule